// File: doc/BRIEF.md
# Indirect ROM Fetch Sequencer

This block drives the program address of a small 4-bit microcontroller. It keeps an 11-bit program counter and a three-level return stack, and it carries out two indirect operations that read the program ROM as data. The indirect table load builds a ROM address from the upper bits of the PC, the accumulator nibble and the RAM nibble. It saves the PC on the return stack, latches the ROM word found at the built address into an 8-bit Q register, and then restores the PC from the stack. The indirect jump reads the ROM word at the same kind of built address and places it in the low byte of the PC.

An instruction-cycle strobe advances the block. A skip flag turns the current instruction into a plain increment. Subroutine call and return strobes reach the same stack, which also makes its contents visible at the ports. The ROM sits outside the block. It returns `rom_data` for the address on `rom_addr` within the same cycle. The PC always holds the address of the next instruction, so an indirect operation placed in the last word of a 256-word group takes its upper address bits from the following group.

Top module: `idx_fetch_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rom_addr` is 0, `q_o` is 0, `busy` is 0, and all stack levels read as 0.
- R2: On a cycle where `cyc_en` is low, nothing changes. On a `cyc_en` cycle with no operation strobe and `busy` low, `rom_addr` steps by one modulo 2048 and runs straight across 64-word page boundaries.
- R3: On a `cyc_en` cycle where `skip` is high and `busy` is low, all operation strobes are ignored. `rom_addr` steps by one, `busy` stays low and the stack keeps its contents.
- R4: An executed table load (`op_tbl`) pushes the current PC onto level 0, shifts level 0 to 1 and level 1 to 2, and discards level 2. It sets `rom_addr` to {PC[10:8], `acc`, `ram_nib`} and raises `busy` for one instruction cycle.
- R5: On the next `cyc_en` cycle of a table load, `q_o` takes `rom_data`. The PC takes level 0, level 1 moves to 0 and level 2 moves to 1, while level 2 keeps its own value. The level that was deepest before the load is therefore lost.
- R6: An executed indirect jump (`op_jmp`) sets `rom_addr` to {PC[10:8], `acc`, `ram_nib`} and raises `busy`. On the next `cyc_en` cycle, PC[7:0] takes `rom_data` and PC[10:8] keeps its value.
- R7: The upper three address bits of an indirect access come from the PC as it stands when the operation executes. For an instruction at address xFF this is already the next 256-word group.
- R8: `op_call` pushes the PC in the same way as R4 and loads `call_tgt`. `op_ret` loads the PC from level 0 and pops the stack in the same way as R5.
- R9: While `busy` is high, the next `cyc_en` cycle completes the operation whatever `skip` and the operation strobes are, and `busy` falls. An executed indirect operation therefore takes two instruction cycles, and a skipped one takes one.
- R10: When several operation strobes are high together, the order of precedence is `op_tbl`, then `op_jmp`, then `op_call`, then `op_ret`.
- R11: `q_o` changes only in the second cycle of a table load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Instruction-cycle strobe |
| skip | input | 1 | Current instruction is skipped |
| op_tbl | input | 1 | Indirect table load |
| op_jmp | input | 1 | Indirect jump |
| op_call | input | 1 | Subroutine call |
| op_ret | input | 1 | Subroutine return |
| call_tgt | input | 11 | Call target address |
| acc | input | 4 | Accumulator nibble |
| ram_nib | input | 4 | RAM(B) nibble |
| rom_data | input | 8 | ROM word at `rom_addr` |
| rom_addr | output | 11 | ROM address (the PC) |
| q_o | output | 8 | Q register |
| busy | output | 1 | Second cycle of an indirect operation |

## Verification
The case that is hardest to reach is the loss of the deepest stack entry during a table load. The stack can only be seen through return operations, so the bench first fills all three levels with distinct call targets. It then runs a table load and follows with three returns, expecting the last two returns to land on the same address. A directed sequence places an indirect jump at address 0FF to show the group crossing. Random stimulus mixes calls, returns, skips, idle strobes and both indirect operations, and each cycle is compared against a bench model of the stack.

// File: rtl/idx_fetch_seq.sv
`timescale 1ns/1ps
module idx_fetch_seq #(
  parameter int PC_W  = 11,
  parameter int NIB_W = 4,
  parameter int STK_D = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_en,
  input  logic                 skip,
  input  logic                 op_tbl,
  input  logic                 op_jmp,
  input  logic                 op_call,
  input  logic                 op_ret,
  input  logic [PC_W-1:0]      call_tgt,
  input  logic [NIB_W-1:0]     acc,
  input  logic [NIB_W-1:0]     ram_nib,
  input  logic [2*NIB_W-1:0]   rom_data,
  output logic [PC_W-1:0]      rom_addr,
  output logic [2*NIB_W-1:0]   q_o,
  output logic                 busy
);
  localparam int LOW_W = 2 * NIB_W;

  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  stk_q [STK_D];
  logic [LOW_W-1:0] q_q;
  logic             busy_q, tbl_q;

  logic go, do_tbl, do_jmp, do_call, do_ret;
  logic [PC_W-1:0] ind_addr;

  assign go       = cyc_en & ~busy_q & ~skip;
  assign do_tbl   = go & op_tbl;
  assign do_jmp   = go & ~op_tbl & op_jmp;
  assign do_call  = go & ~op_tbl & ~op_jmp & op_call;
  assign do_ret   = go & ~op_tbl & ~op_jmp & ~op_call & op_ret;
  assign ind_addr = {pc_q[PC_W-1:LOW_W], acc, ram_nib};

  assign rom_addr = pc_q;
  assign q_o      = q_q;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      q_q    <= '0;
      busy_q <= 1'b0;
      tbl_q  <= 1'b0;
      for (int i = 0; i < STK_D; i++) stk_q[i] <= '0;
    end else if (cyc_en) begin
      if (busy_q) begin
        busy_q <= 1'b0;
        if (tbl_q) begin
          q_q  <= rom_data;
          pc_q <= stk_q[0];
          for (int i = 0; i < STK_D-1; i++) stk_q[i] <= stk_q[i+1];
        end else begin
          pc_q[LOW_W-1:0] <= rom_data;
        end
      end else if (do_tbl || do_call) begin
        stk_q[0] <= pc_q;
        for (int i = 1; i < STK_D; i++) stk_q[i] <= stk_q[i-1];
        pc_q   <= do_tbl ? ind_addr : call_tgt;
        busy_q <= do_tbl;
        tbl_q  <= do_tbl;
      end else if (do_jmp) begin
        pc_q   <= ind_addr;
        busy_q <= 1'b1;
        tbl_q  <= 1'b0;
      end else if (do_ret) begin
        pc_q <= stk_q[0];
        for (int i = 0; i < STK_D-1; i++) stk_q[i] <= stk_q[i+1];
      end else begin
        pc_q <= pc_q + PC_W'(1);
      end
    end
  end

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(rom_addr) && $stable(q_o) && $stable(busy)); // R2

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && !busy && (skip || !(op_tbl || op_jmp || op_call || op_ret))
    |=> rom_addr == PC_W'($past(rom_addr) + PC_W'(1)) && !busy); // R3

  AST_IND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_en && !busy && !skip && (op_tbl || op_jmp)
    |=> busy && rom_addr == {$past(rom_addr[PC_W-1:LOW_W]), $past(acc), $past(ram_nib)}); // R4

  AST_BUSY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc_en |=> !busy); // R9

  AST_Q_TBL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && cyc_en && tbl_q) |=> $stable(q_o)); // R11

  AST_JMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cyc_en && !tbl_q
    |=> rom_addr == {$past(rom_addr[PC_W-1:LOW_W]), $past(rom_data)}); // R6
endmodule

// File: tb/sim_idx_fetch_seq.sv
`timescale 1ns/1ps
module sim_idx_fetch_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cyc_en = 0, skip = 0, op_tbl = 0, op_jmp = 0, op_call = 0, op_ret = 0;
  logic [10:0] call_tgt = '0;
  logic [3:0]  acc = '0, ram_nib = '0;
  logic [7:0]  rom_data;
  logic [10:0] rom_addr;
  logic [7:0]  q_o;
  logic        busy;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [10:0] mpc;
  logic [10:0] ms [3];
  logic [7:0]  mq;
  logic        mbusy, mtbl;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_word(input logic [10:0] a);
    logic [7:0] r;
    r = a[7:0] * 8'd29 + {5'd0, a[10:8]} * 8'd71;
    return r ^ 8'hA5;
  endfunction

  assign rom_data = rom_word(rom_addr);

  idx_fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .skip(skip),
    .op_tbl(op_tbl), .op_jmp(op_jmp), .op_call(op_call), .op_ret(op_ret),
    .call_tgt(call_tgt), .acc(acc), .ram_nib(ram_nib), .rom_data(rom_data),
    .rom_addr(rom_addr), .q_o(q_o), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, int'(rom_addr), int'(mpc));
    chk(req, int'(q_o), int'(mq));
    chk(req, int'(busy), int'(mbusy));
  endtask

  task automatic push_m(input logic [10:0] v);
    ms[2] = ms[1]; ms[1] = ms[0]; ms[0] = v;
  endtask

  task automatic pop_m();
    mpc = ms[0]; ms[0] = ms[1]; ms[1] = ms[2];
  endtask

  task automatic model(input bit ce, sk, t, j, c, r, input logic [10:0] tg,
                       input logic [3:0] a, m);
    if (!ce) return;
    if (mbusy) begin
      mbusy = 0;
      if (mtbl) begin mq = rom_word(mpc); pop_m(); end
      else mpc[7:0] = rom_word(mpc);
    end else if (sk) mpc = mpc + 11'd1;
    else if (t) begin push_m(mpc); mpc = {mpc[10:8], a, m}; mbusy = 1; mtbl = 1; end
    else if (j) begin mpc = {mpc[10:8], a, m}; mbusy = 1; mtbl = 0; end
    else if (c) begin push_m(mpc); mpc = tg; end
    else if (r) pop_m();
    else mpc = mpc + 11'd1;
  endtask

  task automatic step(input bit ce, sk, t, j, c, r, input logic [10:0] tg,
                      input logic [3:0] a, m, input string req);
    cyc_en = ce; skip = sk; op_tbl = t; op_jmp = j; op_call = c; op_ret = r;
    call_tgt = tg; acc = a; ram_nib = m;
    @(posedge clk);
    model(ce, sk, t, j, c, r, tg, a, m);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic call(input logic [10:0] tg, input string req);
    step(1, 0, 0, 0, 1, 0, tg, 0, 0, req);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E3D);
    mpc = 0; mq = 0; mbusy = 0; mtbl = 0;
    for (int i = 0; i < 3; i++) ms[i] = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    // R1: stack reads zero through returns
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R1");
    chk("R1", int'(rom_addr), 0);

    // R2: hold without strobe, page and wrap crossing
    step(0, 0, 1, 1, 1, 1, 11'h155, 4'h9, 4'h9, "R2");
    call(11'h03F, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R2", int'(rom_addr), 11'h040);
    call(11'h7FF, "R2");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    chk("R2", int'(rom_addr), 0);

    // R4 R5: fill stack, table load loses deepest level
    call(11'h111, "R8");
    call(11'h222, "R8");
    call(11'h333, "R8");
    step(1, 0, 1, 0, 0, 0, 0, 4'hA, 4'h5, "R4");
    chk("R4", int'(rom_addr), 11'h3A5);
    chk("R4", int'(busy), 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
    chk("R5", int'(q_o), int'(rom_word(11'h3A5)));
    chk("R5", int'(rom_addr), 11'h333);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    chk("R5", int'(rom_addr), 11'h222);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    chk("R5", int'(rom_addr), 11'h111);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    chk("R5", int'(rom_addr), 11'h111);

    // R7 R6: jump located at 0FF reads group 1
    call(11'h0FF, "R7");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 1, 0, 0, 0, 4'h3, 4'h7, "R7");
    chk("R7", int'(rom_addr), 11'h137);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    chk("R9", int'(busy), 1);
    step(1, 1, 1, 0, 1, 0, 11'h7AA, 0, 0, "R9");
    chk("R6", int'(rom_addr), int'({3'h1, rom_word(11'h137)}));
    chk("R9", int'(busy), 0);

    // R3: skipped table load is one cycle
    call(11'h200, "R3");
    step(1, 1, 1, 0, 0, 0, 0, 4'hF, 4'hF, "R3");
    chk("R3", int'(rom_addr), 11'h201);
    chk("R3", int'(busy), 0);
    step(1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");

    // R10: precedence
    step(1, 0, 0, 1, 1, 1, 11'h444, 4'h1, 4'h2, "R10");
    chk("R10", int'(busy), 1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 1, 1, 11'h444, 0, 0, "R10");
    chk("R10", int'(rom_addr), 11'h444);

    // R11 and random mix
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = int'($urandom % 8);
      step(($urandom % 4) != 0, ($urandom % 5) == 0, k == 0, k == 1, k == 2, k == 3,
           11'($urandom), 4'($urandom), 4'($urandom), "R11");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule